// File: doc/BRIEF.md
# Sample-Rate Timing Divider Selector

This block produces the timing strobes that pace the input or output side of a bank of sample-rate converter channels. Each channel holds a 16-bit timing-select field. The field either routes one serial port's word-select strobe to the channel, or it picks one of five rate sources and divides that source's tick train by a divisor. The divisor is chosen through a 5-bit index into an irregular, roughly geometric table.

Software-visible fields are packed two per 32-bit register and written through a plain write port with a halfword enable. The rate sources are three external clock inputs and two baud-rate generator outputs. They arrive as single-cycle tick strobes in the system clock domain. Each source has its own divider enable bit. Every channel drives one single-cycle output pulse for each completed divide period, or for each word-select strobe it follows. Working out which index best fits a target rate is left to software.

Top module: `srt_timing_sel`

## Requirements
- R1: Only field bits [11:8] (source code) and [4:0] (divider index) are stored. A write is masked with 0x0F1F, so the other bits of a written halfword have no effect on the channel's behaviour.
- R2: Source codes 0, 1, 2, 3 and 4 select tick inputs srcTick[0] to srcTick[4] respectively: external inputs A, B, C, then generator A and generator B. A divided channel counts only the ticks of its selected source.
- R3: Source code 6+w (w below the port count) selects word-select strobe w and bypasses the divider. tmPulse follows wsStrobe[w] one cycle later.
- R4: Divider indices 0 to 3 divide by 2, 4, 6 and 8. After that, even index n divides by 3*2^(n/2) and odd index n divides by 2^((n+3)/2), which gives 12, 16, 24, 32, 48, 64 and so on.
- R5: Index 28 divides by 49152. Index 29 divides by 98304, the largest divisor, because one step of the sequence is skipped after index 28.
- R6: Channel c lives in register c/2. Even channels use bits [15:0] and odd channels use bits [31:16]. wrHalf[0] enables the low half and wrHalf[1] the high half, and a half that is not enabled is not changed and not restarted.
- R7: While pinShare is 1, a selected port 1, 2 or 9 uses the strobe of port 0, port 4 uses port 3, and port 8 uses port 7. Other ports are unchanged.
- R8: divEnable[s+1] gates the divider for source s. While it is 0, that source's ticks are not counted, no pulse is produced, and the count is held until the bit is set again.
- R9: Source code 5, a code 6+w with w not below the port count, and divider index 30 or 31 with a source code 0 to 4 all produce no pulses.
- R10: A write to a channel's field restarts its divide count from zero. A tick in the write cycle is discarded, and no pulse is produced in the cycle after the write.
- R11: Reset clears every field to zero, which means source A divided by 2, and clears all counts and pulses.
- R12: A divided pulse is high for exactly one cycle, in the cycle after the tick that completes the divide period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | REG_AW | Register index (channel/2) |
| wrHalf | input | 2 | Halfword enables: bit 0 low (even channel), bit 1 high (odd channel) |
| wrData | input | 32 | Write data, two packed timing-select fields |
| pinShare | input | 1 | Serial ports share word-select pins |
| divEnable | input | NUM_SRC+1 | Divider enables, bit s+1 for source s, bit 0 unused |
| srcTick | input | NUM_SRC | Single-cycle tick per rate source |
| wsStrobe | input | NUM_PORTS | Word-select strobe per serial port |
| tmPulse | output | NUM_CH | Timing pulse per converter channel |

## Verification
The divided path is driven with continuous ticks, with sparse ticks on every third cycle, and with ticks on a single source while the others are quiet. Continuous ticks pin down each divisor value. Sparse ticks show that the count advances on ticks rather than on clock cycles. Single-source ticks separate the five source codes from one another. Word-select routing is driven with walking and paired port patterns, both with and without pin sharing, so a wrong port or a missing remap shows up as a mismatched bit. Field rewrites that land mid-count with a coincident tick, halfword-masked writes, enable gating in the middle of a count, undefined codes and indices, and one long run through indices 28 and 29 cover the edges of the divisor table.

// File: rtl/srt_pkg.sv
package srt_pkg;

  localparam int MAX_DIVISOR = 98304;
  localparam int CNT_W       = $clog2(MAX_DIVISOR + 1);
  localparam int NUM_SRC     = 5;
  localparam int SRC_W       = 3;
  localparam int CODE_W      = 4;
  localparam int IDX_W       = 5;
  localparam int PORT_W      = 4;
  localparam int WS_BASE     = 6;
  localparam int IDX_COUNT   = 1 << IDX_W;
  localparam logic [15:0] FIELD_MASK = 16'h0F1F;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_DIV = 2'd1,
    MODE_WS  = 2'd2
  } tmode_e;

  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic              restart;
    tmode_e            mode;
    logic [SRC_W-1:0]  srcIdx;
    logic [PORT_W-1:0] wsIdx;
    logic [CNT_W-1:0]  divTerm;   // divisor - 1
  } chan_ctrl_t;

  // Divisor for an index; zero marks an index past the end of the table.
  function automatic logic [CNT_W-1:0] divisor_of(input logic [IDX_W-1:0] idx);
    int divAcc;
    int stepAcc;
    logic [CNT_W-1:0] res;
    divAcc  = 2;
    stepAcc = 2;
    res     = '0;
    for (int i = 0; i < IDX_COUNT; i++) begin
      if ((IDX_W'(i) == idx) && (divAcc <= MAX_DIVISOR)) res = CNT_W'(divAcc);
      if ((i > 2) && ((i % 2) == 1)) stepAcc = stepAcc * 2;
      if (i == 28) begin
        divAcc  = divAcc + stepAcc;
        stepAcc = stepAcc * 2;
      end
      divAcc = divAcc + stepAcc;
    end
    return res;
  endfunction

  // Word-select remap when ports share pins
  function automatic logic [PORT_W-1:0] shared_port(input logic [PORT_W-1:0] p);
    logic [PORT_W-1:0] r;
    case (p)
      PORT_W'(1), PORT_W'(2), PORT_W'(9): r = PORT_W'(0);
      PORT_W'(4):                         r = PORT_W'(3);
      PORT_W'(8):                         r = PORT_W'(7);
      default:                            r = p;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/srt_ctrl.sv
module srt_ctrl
  import srt_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_PORTS = 10,
  localparam int NUM_REG  = (NUM_CH + 1) / 2,
  localparam int REG_AW   = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [1:0]        wrHalf,
  input  logic [31:0]       wrData,
  input  logic              pinShare,
  output chan_ctrl_t        chCtrl [NUM_CH]
);

  localparam logic [CODE_W-1:0] SRC_LAST = CODE_W'(NUM_SRC - 1);
  localparam logic [CODE_W-1:0] WS_FIRST = CODE_W'(WS_BASE);
  localparam int                WS_END   = WS_BASE + NUM_PORTS;

  // Bits outside the stored field positions are discarded by the mask
  logic unusedWrBits;
  assign unusedWrBits = ^{wrData[31:28], wrData[23:21], wrData[15:12], wrData[7:5]};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    localparam int REG  = ch / 2;
    localparam int HALF = ch % 2;

    logic              hit;
    logic [15:0]       newField;
    logic [CODE_W-1:0] codeQ;
    logic [IDX_W-1:0]  idxQ;
    logic [CNT_W-1:0]  divVal;
    logic [PORT_W-1:0] portRaw;
    logic              wsValid;

    assign hit      = wrEn && (wrAddr == REG_AW'(REG)) && wrHalf[HALF];
    assign newField = wrData[HALF*16 +: 16] & FIELD_MASK;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        codeQ <= '0;
        idxQ  <= '0;
      end else if (hit) begin
        codeQ <= newField[11:8];
        idxQ  <= newField[4:0];
      end
    end

    assign divVal  = divisor_of(idxQ);
    assign portRaw = PORT_W'(codeQ - WS_FIRST);
    assign wsValid = (codeQ >= WS_FIRST) && (int'(codeQ) < WS_END);

    always_comb begin
      chCtrl[ch]         = '0;
      chCtrl[ch].restart = hit;
      chCtrl[ch].mode    = MODE_OFF;
      chCtrl[ch].srcIdx  = codeQ[SRC_W-1:0];
      if ((codeQ <= SRC_LAST) && (divVal != '0)) begin
        chCtrl[ch].mode    = MODE_DIV;
        chCtrl[ch].divTerm = divVal - CNT_W'(1);
      end else if (wsValid) begin
        chCtrl[ch].mode  = MODE_WS;
        chCtrl[ch].wsIdx = pinShare ? shared_port(portRaw) : portRaw;
      end
    end
  end

endmodule

// File: rtl/srt_dpath.sv
module srt_dpath
  import srt_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_PORTS = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  chan_ctrl_t           chCtrl [NUM_CH],
  input  logic [NUM_SRC:0]     divEnable,
  input  logic [NUM_SRC-1:0]   srcTick,
  input  logic [NUM_PORTS-1:0] wsStrobe,
  output logic [NUM_CH-1:0]    tmPulse
);

  logic unusedEnBit;
  assign unusedEnBit = divEnable[0];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CNT_W-1:0] cnt;
    logic             pulseQ;
    logic             tick;
    logic             wsBit;

    // Gated tick of the selected source
    always_comb begin
      tick = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (chCtrl[ch].srcIdx == SRC_W'(s)) tick = srcTick[s] & divEnable[s+1];
      end
    end

    // Selected word-select strobe
    always_comb begin
      wsBit = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (chCtrl[ch].wsIdx == PORT_W'(p)) wsBit = wsStrobe[p];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt    <= '0;
        pulseQ <= 1'b0;
      end else if (chCtrl[ch].restart) begin
        cnt    <= '0;
        pulseQ <= 1'b0;
      end else begin
        case (chCtrl[ch].mode)
          MODE_DIV: begin
            pulseQ <= 1'b0;
            if (tick) begin
              if (cnt == chCtrl[ch].divTerm) begin
                cnt    <= '0;
                pulseQ <= 1'b1;
              end else begin
                cnt <= cnt + CNT_W'(1);
              end
            end
          end
          MODE_WS: begin
            cnt    <= '0;
            pulseQ <= wsBit;
          end
          default: begin
            cnt    <= '0;
            pulseQ <= 1'b0;
          end
        endcase
      end
    end

    assign tmPulse[ch] = pulseQ;
  end

endmodule

// File: rtl/srt_timing_sel.sv
module srt_timing_sel
  import srt_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_PORTS = 10,
  localparam int NUM_REG  = (NUM_CH + 1) / 2,
  localparam int REG_AW   = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [REG_AW-1:0]    wrAddr,
  input  logic [1:0]           wrHalf,
  input  logic [31:0]          wrData,
  input  logic                 pinShare,
  input  logic [NUM_SRC:0]     divEnable,
  input  logic [NUM_SRC-1:0]   srcTick,
  input  logic [NUM_PORTS-1:0] wsStrobe,
  output logic [NUM_CH-1:0]    tmPulse
);

  chan_ctrl_t chCtrl [NUM_CH];

  srt_ctrl #(
    .NUM_CH   (NUM_CH),
    .NUM_PORTS(NUM_PORTS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrHalf  (wrHalf),
    .wrData  (wrData),
    .pinShare(pinShare),
    .chCtrl  (chCtrl)
  );

  srt_dpath #(
    .NUM_CH   (NUM_CH),
    .NUM_PORTS(NUM_PORTS)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .chCtrl   (chCtrl),
    .divEnable(divEnable),
    .srcTick  (srcTick),
    .wsStrobe (wsStrobe),
    .tmPulse  (tmPulse)
  );

endmodule

// File: rtl/srt_checker.sv
module srt_checker
  import srt_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_PORTS = 10
) (
  input logic                 clk,
  input logic                 rstN,
  input chan_ctrl_t           chCtrl [NUM_CH],
  input logic [NUM_SRC:0]     divEnable,
  input logic [NUM_SRC-1:0]   srcTick,
  input logic [NUM_PORTS-1:0] wsStrobe,
  input logic [NUM_CH-1:0]    tmPulse
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    logic unusedTerm;
    assign unusedTerm = ^chCtrl[i].divTerm;

    // R10: a rewrite silences the channel for the next cycle
    p_restart_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
      chCtrl[i].restart |=> !tmPulse[i]);

    // R9: an undefined selection never pulses
    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
      (chCtrl[i].mode == MODE_OFF) |=> !tmPulse[i]);

    // R3: word-select mode follows the chosen strobe one cycle later
    p_ws_follow_r3: assert property (@(posedge clk) disable iff (!rstN)
      (chCtrl[i].mode == MODE_WS && !chCtrl[i].restart)
        |=> (tmPulse[i] == $past(wsStrobe[chCtrl[i].wsIdx])));

    // R8: no gated tick, no divided pulse
    p_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
      (chCtrl[i].mode == MODE_DIV &&
       !(srcTick[chCtrl[i].srcIdx] && divEnable[chCtrl[i].srcIdx + 3'd1]))
        |=> !tmPulse[i]);

    // R12: divided pulses last exactly one cycle
    p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
      (chCtrl[i].mode == MODE_DIV && tmPulse[i]) |=> !tmPulse[i]);
  end

endmodule

bind srt_timing_sel srt_checker #(
  .NUM_CH   (NUM_CH),
  .NUM_PORTS(NUM_PORTS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .chCtrl   (chCtrl),
  .divEnable(divEnable),
  .srcTick  (srcTick),
  .wsStrobe (wsStrobe),
  .tmPulse  (tmPulse)
);

// File: tb/tb_srt_timing_sel.sv
module tb_srt_timing_sel;

  logic        clk;
  logic        rstN;
  logic        wrEn;
  logic [0:0]  wrAddr;
  logic [1:0]  wrHalf;
  logic [31:0] wrData;
  logic        pinShare;
  logic [5:0]  divEnable;
  logic [4:0]  srcTick;
  logic [9:0]  wsStrobe;
  logic [3:0]  tmPulse;

  int checks = 0;
  int errors = 0;

  srt_timing_sel dut (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrHalf   (wrHalf),
    .wrData   (wrData),
    .pinShare (pinShare),
    .divEnable(divEnable),
    .srcTick  (srcTick),
    .wsStrobe (wsStrobe),
    .tmPulse  (tmPulse)
  );

  initial clk = 1'b0;
  always #10ns clk = ~clk;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;

  item_t sbq[$];

  // Next-cycle control inputs, applied by step()
  logic        nWrEn = 1'b0;
  logic [0:0]  nAddr = '0;
  logic [1:0]  nHalf = '0;
  logic [31:0] nData = '0;
  logic [5:0]  nDivEn = '0;
  logic        nPin = 1'b0;

  // Reference state from the requirements
  logic [15:0] refField [4];
  int          refCnt [4];

  function automatic int refDiv(input int idx);
    if (idx < 4)   return 2 * (idx + 1);
    if (idx == 29) return 98304;
    if (idx > 29)  return 0;
    if ((idx % 2) == 0) return 3 << (idx / 2);
    return 1 << ((idx + 3) / 2);
  endfunction

  function automatic int refShare(input int p);
    case (p)
      1, 2, 9: return 0;
      4:       return 3;
      8:       return 7;
      default: return p;
    endcase
  endfunction

  task automatic step(input logic [4:0] tk, input logic [9:0] ws, input string tag);
    item_t it;
    logic [3:0] e;
    @(negedge clk);
    wrEn = nWrEn; wrAddr = nAddr; wrHalf = nHalf; wrData = nData;
    divEnable = nDivEn; pinShare = nPin; srcTick = tk; wsStrobe = ws;
    e = '0;
    for (int c = 0; c < 4; c++) begin
      logic hit;
      int ci;
      int ii;
      int d;
      hit = nWrEn && (nAddr == 1'(c / 2)) && nHalf[c % 2];
      if (hit) begin
        refField[c] = nData[(c % 2) * 16 +: 16] & 16'h0F1F;
        refCnt[c] = 0;
      end else begin
        ci = int'(refField[c][11:8]);
        ii = int'(refField[c][4:0]);
        d  = refDiv(ii);
        if (ci <= 4 && d != 0) begin
          if (tk[ci] && nDivEn[ci + 1]) begin
            if (refCnt[c] == d - 1) begin
              refCnt[c] = 0;
              e[c] = 1'b1;
            end else begin
              refCnt[c] = refCnt[c] + 1;
            end
          end
        end else if (ci >= 6 && ci - 6 < 10) begin
          int p;
          p = ci - 6;
          if (nPin) p = refShare(p);
          e[c] = ws[p];
        end
      end
    end
    it.exp = e;
    it.tag = tag;
    sbq.push_back(it);
    nWrEn = 1'b0;
  endtask

  task automatic run(input int n, input logic [4:0] tk, input logic [9:0] ws, input string tag);
    for (int k = 0; k < n; k++) step(tk, ws, tag);
  endtask

  task automatic setField(input int c, input logic [15:0] v, input logic [4:0] tk, input string tag);
    nWrEn = 1'b1;
    nAddr = 1'(c / 2);
    nHalf = 2'(1 << (c % 2));
    nData = (c % 2 == 1) ? {v, 16'h0000} : {16'h0000, v};
    step(tk, '0, tag);
  endtask

  task automatic writeReg(input logic [0:0] a, input logic [1:0] h, input logic [31:0] d, input string tag);
    nWrEn = 1'b1; nAddr = a; nHalf = h; nData = d;
    step('0, '0, tag);
  endtask

  // Monitor: pop one expected vector per cycle and compare
  initial begin
    forever begin
      @(posedge clk);
      #5ns;
      if (rstN && sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (tmPulse !== it.exp) begin
          errors++;
          $display("FAIL %s: tmPulse got %b expected %b at %0t", it.tag, tmPulse, it.exp, $time);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      refField[c] = '0;
      refCnt[c] = 0;
    end
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrHalf = '0; wrData = '0;
    pinShare = 1'b0; divEnable = '0; srcTick = '0; wsStrobe = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (tmPulse !== 4'b0000) begin
      errors++;
      $display("FAIL R11 reset: tmPulse got %b expected 0000", tmPulse);
    end
    rstN = 1'b1;

    // R11: reset field means source A divided by 2 on every channel
    nDivEn = 6'b000010;
    run(6, 5'b00001, '0, "R11 reset field /2 on A");

    // R1 and R12: junk outside mask ignored, pulse one cycle after completing tick
    nDivEn = 6'b111110;
    setField(0, 16'hF0E1, 5'b00000, "R1 masked write");
    run(9, 5'b00001, '0, "R1 R12 /4 with junk bits");

    // R2: each source code counts only its own source
    setField(0, 16'h0000, '0, "R2 set ch0 A");
    setField(1, 16'h0100, '0, "R2 set ch1 B");
    setField(2, 16'h0200, '0, "R2 set ch2 C");
    setField(3, 16'h0300, '0, "R2 set ch3 genA");
    run(4, 5'b00010, '0, "R2 only B ticks");
    run(4, 5'b01000, '0, "R2 only genA ticks");
    run(4, 5'b00100, '0, "R2 only C ticks");
    setField(0, 16'h0400, '0, "R2 set ch0 genB");
    run(4, 5'b10000, '0, "R2 only genB ticks");
    run(4, 5'b00001, '0, "R2 only A ticks");

    // R4: divisor sequence
    setField(0, 16'h0002, '0, "R4 idx2");
    setField(1, 16'h0003, '0, "R4 idx3");
    setField(2, 16'h0004, '0, "R4 idx4");
    setField(3, 16'h0005, '0, "R4 idx5");
    run(50, 5'b00001, '0, "R4 /6 /8 /12 /16 continuous");
    for (int k = 0; k < 60; k++) step((k % 3 == 0) ? 5'b00001 : 5'b00000, '0, "R4 sparse ticks");
    setField(0, 16'h0006, '0, "R4 idx6");
    setField(1, 16'h0007, '0, "R4 idx7");
    setField(2, 16'h0008, '0, "R4 idx8");
    setField(3, 16'h0009, '0, "R4 idx9");
    run(200, 5'b00001, '0, "R4 /24 /32 /48 /64");

    // R8: divider enable gating holds the count
    setField(0, 16'h0001, '0, "R8 ch0 /4 A");
    setField(1, 16'h0101, '0, "R8 ch1 /4 B");
    nDivEn = 6'b000100;
    run(6, 5'b00011, '0, "R8 A disabled B enabled");
    nDivEn = 6'b000110;
    run(7, 5'b00011, '0, "R8 A resumes from held count");

    // R10: rewrite restarts the count, coincident tick discarded
    nDivEn = 6'b111110;
    setField(0, 16'h0001, '0, "R10 ch0 /4");
    run(3, 5'b00001, '0, "R10 partial count");
    setField(0, 16'h0001, 5'b00001, "R10 rewrite with tick");
    run(5, 5'b00001, '0, "R10 full period after restart");

    // R6: halfword enables and channel placement
    run(2, 5'b00001, '0, "R6 settle");
    writeReg(1'b0, 2'b01, 32'h0003_0000, "R6 low half only");
    run(10, 5'b00001, '0, "R6 ch0 /2 ch1 unchanged");
    writeReg(1'b1, 2'b11, 32'h0002_0001, "R6 both halves reg1");
    run(10, 5'b00001, '0, "R6 ch2 /4 ch3 /6");

    // R3: word-select routing without sharing
    setField(0, 16'h0600, '0, "R3 ch0 port0");
    setField(1, 16'h0B00, '0, "R3 ch1 port5");
    setField(2, 16'h0F00, '0, "R3 ch2 port9");
    setField(3, 16'h0700, '0, "R3 ch3 port1");
    for (int p = 0; p < 10; p++) step('0, 10'(1 << p), "R3 walking port");
    step('0, 10'b10_0010_0011, "R3 paired ports");
    step('0, 10'b00_0000_0000, "R3 idle");

    // R7: pin sharing remap
    nPin = 1'b1;
    setField(0, 16'h0700, '0, "R7 ch0 port1");
    setField(1, 16'h0A00, '0, "R7 ch1 port4");
    setField(2, 16'h0E00, '0, "R7 ch2 port8");
    setField(3, 16'h0900, '0, "R7 ch3 port3");
    for (int p = 0; p < 10; p++) step('0, 10'(1 << p), "R7 walking port shared");
    step('0, 10'b01_1000_1001, "R7 shared pairs");
    setField(3, 16'h0F00, '0, "R7 ch3 port9");
    for (int p = 0; p < 10; p++) step('0, 10'(1 << p), "R7 port9 to port0");
    nPin = 1'b0;

    // R9: undefined selections stay silent
    setField(0, 16'h0500, '0, "R9 code5");
    setField(1, 16'h001E, '0, "R9 idx30");
    setField(2, 16'h011F, '0, "R9 idx31");
    setField(3, 16'h0001, '0, "R9 ch3 reference /4");
    run(12, 5'b11111, 10'h3FF, "R9 all ticks and strobes");

    // R5: top of table, index 28 and 29 together
    setField(0, 16'h001D, '0, "R5 ch0 idx29");
    setField(1, 16'h001C, '0, "R5 ch1 idx28");
    setField(2, 16'h0500, '0, "R5 ch2 off");
    setField(3, 16'h0500, '0, "R5 ch3 off");
    run(98305, 5'b00001, '0, "R5 /49152 and /98304");

    repeat (3) @(negedge clk);
    checks++;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL R12 scoreboard: pending got %0d expected 0", sbq.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule